// File: doc/BRIEF.md
# Square Tone Channel With Volume Envelope

The block is one programmable square-wave voice for a sound subsystem. A duty-cycle selector picks how many of the eight steps of each wave period are high. An 11-bit frequency value sets the step period: the counter counts from the value up to 2048, so larger values give higher pitch. A 4-bit volume envelope can ramp the loudness up or down by one level every few envelope ticks, or hold it fixed.

Software programs the channel through a byte-wide write port with four register selects. Writing the frequency-high register with its top bit set restarts the voice. On every system clock the channel presents a 4-bit amplitude sample. The sample is the current envelope volume while the wave is high and the channel has been started, and zero otherwise. An activity output reports that the voice has been started since reset.

Two free-running dividers time the block. A step enable fires once every `PRE_DIV` clocks, and an envelope enable fires once every `ENV_DIV` clocks. The default `ENV_DIV` gives a 64 Hz envelope tick from a 4.19 MHz system clock.

Top module: `sq_tone_chan`

## Requirements
- R1: After reset, `sample_o` is 0 and `active_o` is 0. The stored duty code is 2'b10 (50%), and the envelope and frequency registers are 0.
- R2: A write (`wr_en_i` high at a clock edge) updates one register, chosen by `wr_sel_i`. Select 0 sets the duty code from data bits 7..6. Select 1 sets the envelope configuration. Select 2 sets frequency bits 7..0. Select 3 sets frequency bits 10..8 from data bits 2..0, and data bit 7 is the restart request. A select-3 write with bit 7 clear does not disturb the running waveform or volume.
- R3: The wave steps through 8 positions, 0 to 7. Duty code 00 is high on position 7 only. Code 01 is high on positions 6..7, code 10 on positions 4..7, and code 11 on positions 2..7.
- R4: The step enable fires on every clock edge whose count since reset release is a multiple of `PRE_DIV`. The position advances once every (2048 − frequency) step enables. Counting starts after the restart edge.
- R5: A restart edge sets the position to 0 and loads the full period. It loads the volume from the initial-volume field and sets `active_o`. Frequency bits written by the restarting write take effect at once.
- R6: The envelope configuration byte holds the initial volume in bits 7..4, the direction in bit 3 (1 = up, 0 = down) and the rate n in bits 2..0. The envelope enable fires on every edge whose count since reset release is a multiple of `ENV_DIV`. With n ≠ 0, the volume moves by one after every n envelope enables counted from the restart.
- R7: With rate 0 the volume stays at the initial value, whatever the direction bit.
- R8: The volume saturates: it does not rise above 15 and does not fall below 0.
- R9: `sample_o` equals the volume while the wave is high and the channel is active, and is 0 otherwise.
- R10: Once set, `active_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 duty, 1 envelope, 2 freq low, 3 freq high/restart |
| wr_data_i | input | 8 | Write data |
| sample_o | output | 4 | Amplitude sample |
| active_o | output | 1 | Channel started since reset |

## Verification
The assertions assume that at most one register is written per clock. They also assume the envelope configuration and the restart never arrive in the same cycle, which the single write port guarantees, and that both divider parameters are at least 2. The bench drives every write as a one-cycle pulse launched on the falling edge. It uses a short envelope divider so that ramps and saturation fit in a few hundred cycles. It issues each restart only after the envelope configuration and frequency low byte are already written. Expected samples come from closed-form counts of step and envelope enables between the restart edge and the sampled edge.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int FREQ_W = 11;
  localparam int VOL_W  = 4;
  localparam int RATE_W = 3;
  localparam int STEP_W = 3;
  localparam int DUTY_W = 2;

  typedef enum logic [1:0] {
    SEL_DUTY = 2'd0,
    SEL_ENV  = 2'd1,
    SEL_FLO  = 2'd2,
    SEL_FHI  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [VOL_W-1:0]  init;
    logic              up;
    logic [RATE_W-1:0] rate;
  } env_cfg_t;

  // first wave position that is high for a duty code
  function automatic logic [STEP_W-1:0] first_high_step(input logic [DUTY_W-1:0] duty);
    case (duty)
      2'd0:    return 3'd7;
      2'd1:    return 3'd6;
      2'd2:    return 3'd4;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/sq_timebase.sv
module sq_timebase #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign strobe_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (strobe_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sq_wave.sv
module sq_wave
  import sq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              high_o
);
  localparam int PW = FREQ_W + 1;

  logic [PW-1:0]     cnt_q;
  logic [PW-1:0]     reload;
  logic [STEP_W-1:0] step_q;

  assign reload = PW'(1 << FREQ_W) - {1'b0, freq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= '0;
    end else if (restart_i) begin
      cnt_q  <= reload;
      step_q <= '0;
    end else if (tick_i) begin
      if (cnt_q <= PW'(1)) begin
        cnt_q  <= reload;
        step_q <= step_q + 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign high_o = (step_q >= first_high_step(duty_i));
endmodule

// File: rtl/sq_env.sv
module sq_env
  import sq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  env_cfg_t         cfg_i,
  output logic [VOL_W-1:0] vol_o
);
  localparam logic [VOL_W-1:0] VMAX = '1;

  logic [RATE_W-1:0] div_q;
  logic              due;

  assign due = ({1'b0, div_q} + 1'b1) >= {1'b0, cfg_i.rate};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_o <= '0;
      div_q <= '0;
    end else if (restart_i) begin
      vol_o <= cfg_i.init;
      div_q <= '0;
    end else if (tick_i && cfg_i.rate != '0) begin
      if (due) begin
        div_q <= '0;
        if (cfg_i.up && vol_o != VMAX)       vol_o <= vol_o + 1'b1;
        else if (!cfg_i.up && vol_o != '0)   vol_o <= vol_o - 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_tone_chan.sv
module sq_tone_chan
  import sq_pkg::*;
#(
  parameter int PRE_DIV = 4,
  parameter int ENV_DIV = 65536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [3:0] sample_o,
  output logic       active_o
);
  localparam int HI_W = FREQ_W - 8;

  logic [DUTY_W-1:0] duty_q;
  env_cfg_t          env_q;
  logic [FREQ_W-1:0] freq_q, freq_nxt;
  logic              trig;
  logic              tick_1m, tick_env;
  logic              wave_high;
  logic [VOL_W-1:0]  vol;

  assign trig = wr_en_i && (wr_sel_i == SEL_FHI) && wr_data_i[7];

  always_comb begin
    freq_nxt = freq_q;
    if (wr_en_i && wr_sel_i == SEL_FLO) freq_nxt[7:0] = wr_data_i;
    if (wr_en_i && wr_sel_i == SEL_FHI) freq_nxt[FREQ_W-1:8] = wr_data_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= 2'b10;
      env_q    <= '0;
      freq_q   <= '0;
      active_o <= 1'b0;
    end else begin
      freq_q <= freq_nxt;
      if (wr_en_i && wr_sel_i == SEL_DUTY) duty_q <= wr_data_i[7:6];
      if (wr_en_i && wr_sel_i == SEL_ENV)  env_q  <= env_cfg_t'(wr_data_i);
      if (trig)                            active_o <= 1'b1;
    end
  end

  sq_timebase #(.DIV(PRE_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_o(tick_1m)
  );

  sq_timebase #(.DIV(ENV_DIV)) u_envdiv (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_o(tick_env)
  );

  sq_wave u_wave (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_1m), .restart_i(trig),
    .freq_i(freq_nxt), .duty_i(duty_q), .high_o(wave_high)
  );

  sq_env u_env (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_env), .restart_i(trig),
    .cfg_i(env_q), .vol_o(vol)
  );

  assign sample_o = (active_o && wave_high) ? vol : '0;
endmodule

// File: rtl/sq_tone_chan_chk.sv
module sq_tone_chan_chk
  import sq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [7:0]       wr_data_i,
  input logic             tick_i,
  input env_cfg_t         cfg_i,
  input logic [VOL_W-1:0] vol_i,
  input logic             high_i,
  input logic             active_i,
  input logic [3:0]       sample_i
);
  logic trig_c, duty_wr_c;
  assign trig_c    = wr_en_i && wr_sel_i == 2'd3 && wr_data_i[7];
  assign duty_wr_c = wr_en_i && wr_sel_i == 2'd0;

  assert_restart_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_c |=> active_i && vol_i == $past(cfg_i.init));

  assert_step_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_c && !tick_i && !duty_wr_c) |=> $stable(high_i));

  assert_rate0_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_c && cfg_i.rate == '0) |=> $stable(vol_i));

  assert_top_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_c && cfg_i.up && vol_i == 4'd15) |=> vol_i == 4'd15);

  assert_bottom_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_c && !cfg_i.up && vol_i == 4'd0) |=> vol_i == 4'd0);

  assert_unit_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_c |=> (vol_i == $past(vol_i)) || (vol_i == $past(vol_i) + 4'd1) ||
                (vol_i + 4'd1 == $past(vol_i)));

  assert_quiet_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> sample_i == 4'd0);

  assert_active_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |=> active_i);
endmodule

bind sq_tone_chan sq_tone_chan_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .tick_i(tick_1m), .cfg_i(env_q), .vol_i(vol),
  .high_i(wave_high), .active_i(active_o), .sample_i(sample_o)
);

// File: tb/sq_tone_chan_tb.sv
module sq_tone_chan_tb;
  localparam int CLK_P = 10;
  localparam int PRE   = 4;
  localparam int ENVD  = 16;

  typedef struct {
    int         at;
    logic [3:0] smp;
    logic       act;
    string      req;
  } item_t;

  item_t q[$];

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [3:0] sample_o;
  logic       active_o;

  int edge_n = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  sq_tone_chan #(.PRE_DIV(PRE), .ENV_DIV(ENVD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .sample_o(sample_o), .active_o(active_o)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) if (rst_ni) edge_n <= edge_n + 1;

  // monitor: compares results as they appear
  always begin
    @(posedge clk);
    #(CLK_P/4);
    while (q.size() > 0 && q[0].at <= edge_n) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.at != edge_n || sample_o !== it.smp || active_o !== it.act) begin
        n_fail++;
        $display("FAIL %s edge %0d: sample=%0d active=%0b expected sample=%0d active=%0b",
                 it.req, edge_n, sample_o, active_o, it.smp, it.act);
      end
    end
  end

  function automatic int exp_smp(int m, int t, int p, int duty, int init, int up, int rate);
    int ticks, step, nh, et, v, n;
    ticks = m / PRE - t / PRE;
    step  = (ticks / p) % 8;
    nh    = (duty == 0) ? 1 : (duty == 1) ? 2 : (duty == 2) ? 4 : 6;
    et    = m / ENVD - t / ENVD;
    v     = init;
    if (rate != 0) begin
      n = et / rate;
      if (up != 0) v = (init + n > 15) ? 15 : init + n;
      else         v = (init - n < 0) ? 0 : init - n;
    end
    return (step >= 8 - nh) ? v : 0;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_sel_i  = sel;
    wr_data_i = data;
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  // configure, restart and queue the expected samples of a window
  task automatic scen(input bit set_duty, input int duty, input int init, input int up,
                      input int rate, input int p, input int win, input bit mid_wr,
                      input string req);
    int f, t;
    f = 2048 - p;
    if (set_duty) wr(2'd0, 8'(duty << 6));
    wr(2'd1, {4'(init), 1'(up), 3'(rate)});
    wr(2'd2, 8'(f & 255));
    @(negedge clk);
    t = edge_n + 1;
    for (int m = t; m <= t + win; m++) begin
      item_t it;
      it.at  = m;
      it.smp = 4'(exp_smp(m, t, p, duty, init, up, rate));
      it.act = 1'b1;
      it.req = req;
      q.push_back(it);
    end
    wr_en_i   = 1'b1;
    wr_sel_i  = 2'd3;
    wr_data_i = {1'b1, 4'd0, 3'(f >> 8)};
    @(negedge clk);
    wr_en_i   = 1'b0;
    if (mid_wr) begin
      repeat (20) @(negedge clk);
      wr(2'd3, {1'b0, 4'd0, 3'(f >> 8)}); // R2: no restart
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset
    for (int i = 0; i < 3; i++) begin
      item_t it;
      it.at = 0; it.smp = 4'd0; it.act = 1'b0; it.req = "R1";
      q.push_back(it);
      @(negedge clk);
    end
    rst_ni = 1'b1;
    // R1: idle after release, before any restart
    for (int m = 1; m <= 6; m++) begin
      item_t it;
      it.at = m; it.smp = 4'd0; it.act = 1'b0; it.req = "R1";
      q.push_back(it);
    end
    while (q.size() > 0) @(negedge clk);

    scen(1'b0, 2, 15, 0, 0, 1,    64, 1'b0, "R1_default_duty_R9");
    scen(1'b1, 0,  9, 1, 0, 2,    80, 1'b0, "R3_code00_R7");
    scen(1'b1, 3,  7, 0, 0, 4,   140, 1'b1, "R3_code11_R2");
    scen(1'b1, 1, 12, 0, 0, 8,   300, 1'b0, "R3_code01_R4");
    scen(1'b1, 3,  5, 0, 1, 1,   120, 1'b0, "R6_down_R8");
    scen(1'b1, 3, 13, 1, 2, 3,   160, 1'b0, "R8_up_sat");
    scen(1'b1, 2, 15, 0, 3, 1,   220, 1'b0, "R6_rate3_R5");
    scen(1'b1, 3, 10, 0, 0, 2048, 40, 1'b0, "R4_long_R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule